// File: doc/BRIEF.md
# Row-Locality-Driven Migration Selector

This block sits beside the controller of the large, slow memory in a hybrid memory system whose small DRAM acts as a cache. It observes every access that reaches the slow memory and decides whether that access found its row already open in the addressed bank's row buffer. Row-buffer hits are nearly as cheap in the slow memory as in DRAM, so they are left alone. Row-buffer misses are where the slow memory loses most, so the block counts them per row. When a row has missed often enough to be worth the cost of moving it, the block raises a one-cycle migrate request naming the bank and row.

Each bank keeps its own record of the open row. Miss counts live in a small fully associative table keyed by bank and row, with least-recently-used replacement. A migrated row's entry is dropped. The whole table is emptied at the end of every fixed quantum, so only recent misses count toward promotion. A threshold input sets how many misses trigger promotion; systems normally program it to 2.

Top module: `rbl_migrate_ctrl`

## Requirements
- R1: Synchronous reset (rst high on a clock edge) empties the stats table, marks every bank as having no open row and restarts the quantum counter. In the cycle after reset, rsp_valid and mig_valid are 0.
- R2: An access is a row-buffer hit (rsp_row_hit=1) only if its bank has an open row equal to acc_row. Every access, hit or miss, makes acc_row the open row of its bank. The first access to a bank after reset is a miss.
- R3: An access to one bank never changes the open row of any other bank.
- R4: A row-buffer hit neither raises a migrate request nor changes any miss count.
- R5: A miss not in a quantum-end cycle adds one to the row's miss count (a new row starts at 1). When the new count is greater than or equal to cfg_threshold, mig_valid is 1 in the next cycle and mig_bank/mig_row carry that access's bank and row.
- R6: When a row migrates, its table entry is removed, so its next miss counts from 1 again.
- R7: With cfg_threshold at 0 or 1, the first miss to an untracked row migrates at once, and the table is left unchanged.
- R8: The table holds 32 rows. A miss to a new row while all 32 are tracked replaces the least recently counted row, and that row's count is lost.
- R9: The quantum counter is 0 in the first cycle after reset and counts to 65535 before it wraps. In the cycle where it reads 65535, the whole table is cleared. An access in that cycle still gets its hit/miss result and updates the open row, but its miss is not counted and raises no migrate.
- R10: All outputs are registered. rsp_valid and rsp_row_hit describe the access of the previous cycle, and rsp_valid and mig_valid are 0 after a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access to the large memory is made this cycle |
| acc_bank | input | 3 | Bank addressed by the access |
| acc_row | input | 14 | Row addressed by the access |
| cfg_threshold | input | 4 | Miss count at which a row is promoted |
| rsp_valid | output | 1 | Result for the previous cycle's access is valid |
| rsp_row_hit | output | 1 | Previous access was a row-buffer hit |
| mig_valid | output | 1 | Migrate request pulse |
| mig_bank | output | 3 | Bank of the row to migrate |
| mig_row | output | 14 | Row to migrate |

## Verification
A stale open-row register shows on rsp_row_hit one cycle after the next access to that bank. A wrong count, key or replacement choice stays hidden until that row misses again, and then shows as a migrate pulse that comes early, late or not at all. For that reason the stimulus sends repeated misses to a few rows, fills the table past capacity, and places accesses on both sides of a quantum end. A failure to clear the table at a quantum end shows up only on the first miss after the boundary, so the bench sends an access exactly into that cycle and another one right after it.

// File: rtl/rbl_pkg.sv
package rbl_pkg;
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_UPDATE  = 2'd1,
    ACT_ALLOC   = 2'd2,
    ACT_RETIRE  = 2'd3
  } tbl_act_e;
endpackage

// File: rtl/rbl_quantum_timer.sv
module rbl_quantum_timer #(
  parameter int QUANTUM = 65536,
  localparam int STAMP_W = $clog2(QUANTUM)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [STAMP_W-1:0] stamp,
  output logic               q_end
);
  logic [STAMP_W-1:0] cnt_q;

  assign stamp = cnt_q;
  assign q_end = (cnt_q == STAMP_W'(QUANTUM - 1));

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (q_end) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rbl_open_rows.sv
module rbl_open_rows #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [ROW_W-1:0]  acc_row,
  output logic              row_hit
);
  logic [NUM_BANKS-1:0] open_vld;
  logic [ROW_W-1:0]     open_row [NUM_BANKS];

  assign row_hit = open_vld[acc_bank] && (open_row[acc_bank] == acc_row);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = acc_valid && (acc_bank == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (rst)      open_vld[g] <= 1'b0;
      else if (sel) open_vld[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) open_row[g] <= acc_row;
    end
  end
endmodule

// File: rtl/rbl_stats_table.sv
module rbl_stats_table
  import rbl_pkg::*;
#(
  parameter int KEY_W   = 17,
  parameter int DEPTH   = 32,
  parameter int CNT_W   = 4,
  parameter int STAMP_W = 16,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_all,
  input  logic               lookup_en,
  input  logic [KEY_W-1:0]   key,
  input  logic [CNT_W-1:0]   thresh,
  input  logic [STAMP_W-1:0] stamp,
  output logic               fire
);
  logic [DEPTH-1:0]   ent_valid;
  logic [KEY_W-1:0]   ent_key   [DEPTH];
  logic [CNT_W-1:0]   ent_cnt   [DEPTH];
  logic [STAMP_W-1:0] ent_stamp [DEPTH];

  logic [DEPTH-1:0]   match_vec;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic               free_any;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   lru_idx;
  logic [STAMP_W-1:0] lru_stamp;
  logic [CNT_W-1:0]   cnt_cur;
  logic [CNT_W-1:0]   cnt_next;
  logic [IDX_W-1:0]   tgt_idx;
  tbl_act_e           act;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign match_vec[g] = ent_valid[g] && (ent_key[g] == key);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    lru_idx   = '0;
    lru_stamp = ent_stamp[0];
    for (int i = 1; i < DEPTH; i++) begin
      if (ent_stamp[i] < lru_stamp) begin
        lru_idx   = IDX_W'(i);
        lru_stamp = ent_stamp[i];
      end
    end
  end

  always_comb begin
    cnt_cur  = hit_any ? ent_cnt[hit_idx] : '0;
    cnt_next = (cnt_cur == {CNT_W{1'b1}}) ? cnt_cur : cnt_cur + 1'b1;
    fire     = lookup_en && (cnt_next >= thresh);
    tgt_idx  = hit_any ? hit_idx : (free_any ? free_idx : lru_idx);
    if (!lookup_en)   act = ACT_NONE;
    else if (fire)    act = hit_any ? ACT_RETIRE : ACT_NONE;
    else              act = hit_any ? ACT_UPDATE : ACT_ALLOC;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_all) begin
      ent_valid <= '0;
    end else begin
      case (act)
        ACT_RETIRE: ent_valid[tgt_idx] <= 1'b0;
        ACT_ALLOC:  ent_valid[tgt_idx] <= 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (act == ACT_UPDATE || act == ACT_ALLOC) begin
      ent_key[tgt_idx]   <= key;
      ent_cnt[tgt_idx]   <= cnt_next;
      ent_stamp[tgt_idx] <= stamp;
    end
  end
endmodule

// File: rtl/rbl_migrate_ctrl.sv
module rbl_migrate_ctrl #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int TBL_DEPTH = 32,
  parameter int CNT_W     = 4,
  parameter int QUANTUM   = 65536,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int KEY_W    = BANK_W + ROW_W,
  localparam int STAMP_W  = $clog2(QUANTUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic [CNT_W-1:0]  cfg_threshold,
  output logic              rsp_valid,
  output logic              rsp_row_hit,
  output logic              mig_valid,
  output logic [BANK_W-1:0] mig_bank,
  output logic [ROW_W-1:0]  mig_row
);
  logic               row_hit;
  logic               q_end;
  logic [STAMP_W-1:0] stamp;
  logic               lookup_en;
  logic               fire;

  rbl_quantum_timer #(.QUANTUM(QUANTUM)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .stamp (stamp),
    .q_end (q_end)
  );

  rbl_open_rows #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_rows (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_bank  (acc_bank),
    .acc_row   (acc_row),
    .row_hit   (row_hit)
  );

  assign lookup_en = acc_valid && !row_hit && !q_end;

  rbl_stats_table #(
    .KEY_W(KEY_W), .DEPTH(TBL_DEPTH), .CNT_W(CNT_W), .STAMP_W(STAMP_W)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .clear_all (q_end),
    .lookup_en (lookup_en),
    .key       ({acc_bank, acc_row}),
    .thresh    (cfg_threshold),
    .stamp     (stamp),
    .fire      (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_row_hit <= 1'b0;
      mig_valid   <= 1'b0;
      mig_bank    <= '0;
      mig_row     <= '0;
    end else begin
      rsp_valid   <= acc_valid;
      rsp_row_hit <= acc_valid && row_hit;
      mig_valid   <= fire;
      if (fire) begin
        mig_bank <= acc_bank;
        mig_row  <= acc_row;
      end
    end
  end
endmodule

// File: rtl/rbl_migrate_ctrl_chk.sv
module rbl_migrate_ctrl_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [BANK_W-1:0] acc_bank,
  input logic [ROW_W-1:0]  acc_row,
  input logic              rsp_valid,
  input logic              rsp_row_hit,
  input logic              mig_valid,
  input logic [BANK_W-1:0] mig_bank,
  input logic [ROW_W-1:0]  mig_row
);
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !mig_valid)); // R1

  AST_SAME_ROW_HITS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_valid) && acc_valid && acc_bank == $past(acc_bank)
     && acc_row == $past(acc_row)) |=> rsp_row_hit); // R2

  AST_NO_MIG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    mig_valid |-> (rsp_valid && !rsp_row_hit)); // R4

  AST_MIG_NAMES_ACCESS: assert property (@(posedge clk) disable iff (rst)
    mig_valid |-> (mig_bank == $past(acc_bank) && mig_row == $past(acc_row))); // R5

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!rsp_valid && !mig_valid)); // R10

  AST_RSP_FOLLOWS_ACC: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid); // R10
endmodule

bind rbl_migrate_ctrl rbl_migrate_ctrl_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_valid   (acc_valid),
  .acc_bank    (acc_bank),
  .acc_row     (acc_row),
  .rsp_valid   (rsp_valid),
  .rsp_row_hit (rsp_row_hit),
  .mig_valid   (mig_valid),
  .mig_bank    (mig_bank),
  .mig_row     (mig_row)
);

// File: tb/rbl_migrate_ctrl_test.sv
module rbl_migrate_ctrl_test;
  localparam int NB = 8;
  localparam int RW = 14;
  localparam int BW = 3;
  localparam int DEPTH = 32;
  localparam int QUANT = 65536;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic [BW-1:0] acc_bank = '0;
  logic [RW-1:0] acc_row = '0;
  logic [3:0]    cfg_threshold = 4'd2;
  logic          rsp_valid, rsp_row_hit, mig_valid;
  logic [BW-1:0] mig_bank;
  logic [RW-1:0] mig_row;

  always #5 clk = ~clk;

  rbl_migrate_ctrl uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_bank(acc_bank),
    .acc_row(acc_row), .cfg_threshold(cfg_threshold), .rsp_valid(rsp_valid),
    .rsp_row_hit(rsp_row_hit), .mig_valid(mig_valid), .mig_bank(mig_bank),
    .mig_row(mig_row)
  );

  typedef struct { int key; int cnt; } ent_t;

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    done  = 0;

  bit    m_open_ok [NB];
  int    m_open_row [NB];
  ent_t  m_lru [$];
  int    m_qcnt = 0;
  bit    e_rsp, e_hit, e_mig;
  int    e_bank, e_row;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s) at %0t: actual %0d expected %0d", req, phase, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin m_open_ok[i] = 0; m_open_row[i] = 0; end
    m_lru.delete();
    m_qcnt = 0;
    e_rsp = 0; e_hit = 0; e_mig = 0; e_bank = 0; e_row = 0;
  endtask

  task automatic model_step(input bit v, input int b, input int r, input int thr);
    bit qend = (m_qcnt == QUANT - 1);
    bit hit = 0;
    e_rsp = v; e_hit = 0; e_mig = 0;
    if (v) begin
      hit = m_open_ok[b] && (m_open_row[b] == r);
      e_hit = hit;
      m_open_ok[b] = 1; m_open_row[b] = r;
      if (!hit && !qend) begin
        int key = b * 65536 + r;
        int pos = -1;
        int c;
        for (int i = 0; i < m_lru.size(); i++) if (m_lru[i].key == key) pos = i;
        c = (pos >= 0) ? m_lru[pos].cnt + 1 : 1;
        if (c > 15) c = 15;
        if (pos >= 0) m_lru.delete(pos);
        if (c >= thr) begin
          e_mig = 1; e_bank = b; e_row = r;
        end else begin
          ent_t n;
          if (pos < 0 && m_lru.size() == DEPTH) m_lru.delete(0);
          n.key = key; n.cnt = c;
          m_lru.push_back(n);
        end
      end
    end
    if (qend) begin m_lru.delete(); m_qcnt = 0; end
    else m_qcnt++;
  endtask

  task automatic compare();
    check("R10", int'(rsp_valid), int'(e_rsp));
    check("R2", int'(rsp_row_hit), int'(e_hit));
    check("R5", int'(mig_valid), int'(e_mig));
    if (e_mig) begin
      check("R5", int'(mig_bank), e_bank);
      check("R5", int'(mig_row), e_row);
    end
  endtask

  task automatic step(input bit v, input int b, input int r);
    acc_valid = v; acc_bank = BW'(b); acc_row = RW'(r);
    @(posedge clk);
    model_step(v, b, r, int'(cfg_threshold));
    @(negedge clk);
    compare();
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    phase = "R1";
    check("R1", int'(rsp_valid), 0);
    check("R1", int'(mig_valid), 0);

    phase = "R2";
    step(1, 0, 5); step(1, 0, 5); step(1, 0, 6); step(1, 0, 5); step(0, 0, 0);
    phase = "R3";
    step(1, 1, 7); step(1, 2, 7); step(1, 1, 7); step(1, 2, 9); step(1, 1, 7);
    phase = "R4";
    for (int i = 0; i < 10; i++) step(1, 1, 7);
    phase = "R5";
    cfg_threshold = 4'd3;
    step(1, 3, 100); step(1, 3, 200); step(1, 3, 100); step(1, 3, 200); step(1, 3, 100);
    phase = "R6";
    step(1, 3, 200); step(1, 3, 100); step(1, 3, 200); step(1, 3, 100);
    phase = "R7";
    cfg_threshold = 4'd1;
    step(1, 6, 11); step(1, 6, 12);
    cfg_threshold = 4'd0;
    step(1, 6, 13);
    phase = "R8";
    cfg_threshold = 4'd2;
    for (int i = 0; i < 33; i++) step(1, 4, 1000 + i);
    step(1, 4, 1002); step(1, 4, 1000); step(1, 4, 1001); step(1, 4, 1003);
    phase = "R10";
    for (int i = 0; i < 60000; i++) begin
      if (i % 500 == 0) cfg_threshold = 4'($urandom_range(0, 4));
      step(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, NB - 1)),
           int'($urandom_range(0, 5)));
    end
    phase = "R9";
    cfg_threshold = 4'd2;
    while (m_qcnt != QUANT - 3) step(0, 0, 0);
    step(1, 5, 9);
    step(1, 5, 10);
    step(1, 5, 9);
    step(1, 5, 10);
    step(1, 5, 9);
    step(1, 5, 10);
    phase = "R8";
    for (int i = 0; i < 5000; i++) begin
      if (i % 300 == 0) cfg_threshold = 4'($urandom_range(1, 4));
      step(1'b1, int'($urandom_range(0, 1)), int'($urandom_range(0, 40)));
    end
    step(0, 0, 0);
    done = 1;
    report();
  end
endmodule